// File: doc/BRIEF.md
# Raster Sync Timing Generator with External Lock

This block produces horizontal sync, vertical sync and a combined blanking signal for a raster display. It runs entirely from the video clock, which is some multiple of the dot clock. A horizontal counter steps once per video clock and wraps at a programmed total. A line counter steps once per line and wraps at its own programmed total. Sync and blank come from comparing each counter against a small set of programmed boundaries.

Each sync pin is bidirectional and has three signals: an input, an output and an output enable. When a pin is set as an output, the block drives it low during the sync interval from its own counters. When a pin is set as an input, a falling edge arriving on it loads the matching counter with a programmed value. This lets the raster follow an external timing source and absorb any pipeline delay in front of it. The horizontal load can be aimed at any clock position in the line. The vertical load can be aimed at any line. After reset both pins are inputs.

Software writes through a simple write port into a staging bank. The whole bank becomes live only at the last clock of a frame, so a frame is never drawn with a mix of old and new timing.

Top module: `raster_sync_gen`

## Requirements
- R1: The horizontal counter counts 0..HTOT and then returns to 0, so a line lasts HTOT+1 clocks. hsync_out is low exactly while the horizontal count is below HSE.
- R2: The line counter steps when the horizontal counter is at or above HTOT, and it wraps from VTOT to 0. vsync_out is low exactly while the line count is below VSE.
- R3: blank is high when the horizontal count is at or above HBS or below HBE, or when the line count is at or above VBS or below VBE.
- R4: The register addresses are: 0 = direction (bit 0 = horizontal pin drives when 1, bit 1 = vertical pin drives when 1), 1 = HSE, 2 = HBE, 3 = HBS, 4 = HTOT, 5 = VSE, 6 = VBE, 7 = VBS, 8 = VTOT, 9 = horizontal load value, 10 = vertical load value. A write to any other address is dropped.
- R5: After reset, hsync_oe and vsync_oe are both 0, and every live register is 0.
- R6: hsync_oe follows live direction bit 0 and vsync_oe follows live direction bit 1. The sync outputs always carry the internal timing, whatever the pin direction.
- R7: With the horizontal pin set as an input, a falling edge on hsync_in is seen through a two-flop synchronizer. The horizontal counter then holds the horizontal load value after the third rising clock edge that follows the input change.
- R8: With the vertical pin set as an input, a falling edge on vsync_in loads the line counter with the vertical load value. It uses the same three-edge timing as R7.
- R9: Writes land in a staging bank. The live bank copies the staging bank only on the last clock of a frame, when both counters are at their totals. A change is therefore first seen on the first clock of the next frame.
- R10: A pin that is set as an output ignores edges on its input. Edges on hsync_in or vsync_in do not disturb the timing of that axis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | CW | Register write data |
| hsync_in | input | 1 | External horizontal sync, falling edge used |
| hsync_out | output | 1 | Internal horizontal sync, active low |
| hsync_oe | output | 1 | Drive enable for the horizontal sync pin |
| vsync_in | input | 1 | External vertical sync, falling edge used |
| vsync_out | output | 1 | Internal vertical sync, active low |
| vsync_oe | output | 1 | Drive enable for the vertical sync pin |
| blank | output | 1 | Combined blanking, active high |

## Verification
The bench keeps the default widths (12-bit counters, 4-bit addresses) but programs two very small rasters. The first is 10 clocks by 6 lines and the second is 7 clocks by 4 lines. Because the rasters are so small, two whole frames of each can be compared cycle by cycle against counter positions that the bench computes arithmetically. The same small totals let the bench reach the frame-end hand-over of the staging bank within a few dozen cycles. They also let it place external sync edges at known counter positions, so that a load shows up as a clear jump in the sync pattern.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int unsigned NREG = 11;
  localparam int unsigned RA_DIR  = 0;
  localparam int unsigned RA_HSE  = 1;
  localparam int unsigned RA_HBE  = 2;
  localparam int unsigned RA_HBS  = 3;
  localparam int unsigned RA_HTOT = 4;
  localparam int unsigned RA_VSE  = 5;
  localparam int unsigned RA_VBE  = 6;
  localparam int unsigned RA_VBS  = 7;
  localparam int unsigned RA_VTOT = 8;
  localparam int unsigned RA_HLD  = 9;
  localparam int unsigned RA_VLD  = 10;
  localparam int unsigned DIR_H_BIT = 0;
  localparam int unsigned DIR_V_BIT = 1;
endpackage

// File: rtl/rsg_fall_sync.sv
module rsg_fall_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[i] <= 1'b1;
        else if (i == 0) chain_q[i] <= async_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain_q[STAGES-1];
  end

  assign fall_o = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/rsg_axis.sv
module rsg_axis #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] total_i,
  input  logic [CW-1:0] sync_end_i,
  input  logic [CW-1:0] blank_start_i,
  input  logic [CW-1:0] blank_end_i,
  output logic [CW-1:0] cnt_o,
  output logic          at_end_o,
  output logic          sync_act_o,
  output logic          blank_o
);
  function automatic logic f_in_sync(input logic [CW-1:0] c, input logic [CW-1:0] e);
    return c < e;
  endfunction

  function automatic logic f_in_blank(input logic [CW-1:0] c, input logic [CW-1:0] bs,
                                      input logic [CW-1:0] be);
    return (c >= bs) || (c < be);
  endfunction

  function automatic logic [CW-1:0] f_next(input logic [CW-1:0] c, input logic wrap);
    return wrap ? '0 : c + 1'b1;
  endfunction

  logic [CW-1:0] cnt_q;

  assign at_end_o   = cnt_q >= total_i;
  assign sync_act_o = f_in_sync(cnt_q, sync_end_i);
  assign blank_o    = f_in_blank(cnt_q, blank_start_i, blank_end_i);
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= f_next(cnt_q, at_end_o);
  end
endmodule

// File: rtl/rsg_regbank.sv
module rsg_regbank
  import rsg_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned AW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [CW-1:0]             wr_data,
  input  logic                      commit_i,
  output logic [NREG-1:0][CW-1:0]   live_o
);
  logic [NREG-1:0][CW-1:0] stage_q;
  logic [NREG-1:0][CW-1:0] live_q;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_q[i] <= '0;
          live_q[i]  <= '0;
        end else begin
          if (wr_en && (wr_addr == AW'(i))) stage_q[i] <= wr_data;
          if (commit_i) live_q[i] <= stage_q[i];
        end
      end
    end
  endgenerate

  assign live_o = live_q;
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import rsg_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned AW = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          hsync_in,
  output logic          hsync_out,
  output logic          hsync_oe,
  input  logic          vsync_in,
  output logic          vsync_out,
  output logic          vsync_oe,
  output logic          blank
);
  logic [NREG-1:0][CW-1:0] live;
  logic [CW-1:0] hcnt, vcnt;
  logic h_fall, v_fall, h_load, v_load;
  logic h_at_end, v_at_end, frame_end;
  logic h_sync_act, v_sync_act, h_blank, v_blank;
  logic h_drive, v_drive;

  assign h_drive   = live[RA_DIR][DIR_H_BIT];
  assign v_drive   = live[RA_DIR][DIR_V_BIT];
  assign frame_end = h_at_end & v_at_end;
  assign h_load    = h_fall & ~h_drive;
  assign v_load    = v_fall & ~v_drive;

  rsg_regbank #(.CW(CW), .AW(AW)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_i(frame_end), .live_o(live)
  );

  rsg_fall_sync #(.STAGES(SYNC_STAGES)) hsync_det_i (
    .clk(clk), .rst_n(rst_n), .async_i(hsync_in), .fall_o(h_fall)
  );

  rsg_fall_sync #(.STAGES(SYNC_STAGES)) vsync_det_i (
    .clk(clk), .rst_n(rst_n), .async_i(vsync_in), .fall_o(v_fall)
  );

  rsg_axis #(.CW(CW)) h_axis_i (
    .clk(clk), .rst_n(rst_n), .step_i(1'b1), .load_i(h_load),
    .load_val_i(live[RA_HLD]), .total_i(live[RA_HTOT]),
    .sync_end_i(live[RA_HSE]), .blank_start_i(live[RA_HBS]),
    .blank_end_i(live[RA_HBE]), .cnt_o(hcnt), .at_end_o(h_at_end),
    .sync_act_o(h_sync_act), .blank_o(h_blank)
  );

  rsg_axis #(.CW(CW)) v_axis_i (
    .clk(clk), .rst_n(rst_n), .step_i(h_at_end), .load_i(v_load),
    .load_val_i(live[RA_VLD]), .total_i(live[RA_VTOT]),
    .sync_end_i(live[RA_VSE]), .blank_start_i(live[RA_VBS]),
    .blank_end_i(live[RA_VBE]), .cnt_o(vcnt), .at_end_o(v_at_end),
    .sync_act_o(v_sync_act), .blank_o(v_blank)
  );

  assign hsync_out = ~h_sync_act;
  assign vsync_out = ~v_sync_act;
  assign hsync_oe  = h_drive;
  assign vsync_oe  = v_drive;
  assign blank     = h_blank | v_blank;
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker
  import rsg_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CW-1:0]           hcnt,
  input logic [CW-1:0]           vcnt,
  input logic                    h_at_end,
  input logic                    h_load,
  input logic                    v_load,
  input logic                    h_fall,
  input logic                    frame_end,
  input logic                    hsync_oe,
  input logic                    vsync_oe,
  input logic [NREG-1:0][CW-1:0] live
);
  // R1: line wraps to zero after the total
  a_r1_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (h_at_end && !h_load) |=> (hcnt == '0));

  // R1: counter steps by one inside the line
  a_r1_h_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_at_end && !h_load) |=> (hcnt == CW'($past(hcnt) + 1'b1)));

  // R2: line counter holds between line ends
  a_r2_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_at_end && !v_load) |=> $stable(vcnt));

  // R6 and R9: a pin turns to output only across a frame end
  a_r6_h_dir: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_oe) |-> $past(frame_end));

  a_r6_v_dir: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_oe) |-> $past(frame_end));

  // R9: live bank is untouched away from frame ends
  a_r9_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(live));

  // R7: horizontal load value lands in the counter
  a_r7_h_load: assert property (@(posedge clk) disable iff (!rst_n)
    h_load |=> (hcnt == $past(live[RA_HLD])));

  // R8: vertical load value lands in the line counter
  a_r8_v_load: assert property (@(posedge clk) disable iff (!rst_n)
    v_load |=> (vcnt == $past(live[RA_VLD])));

  // R10: an edge on a driven pin leaves the count stepping
  a_r10_h_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (h_fall && hsync_oe && !h_at_end) |=> (hcnt == CW'($past(hcnt) + 1'b1)));
endmodule

bind raster_sync_gen rsg_checker #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .h_at_end(h_at_end),
  .h_load(h_load), .v_load(v_load), .h_fall(h_fall), .frame_end(frame_end),
  .hsync_oe(hsync_oe), .vsync_oe(vsync_oe), .live(live)
);

// File: tb/raster_sync_gen_tb.sv
`timescale 1ns/1ps
module raster_sync_gen_tb_top;
  localparam int CW = 12;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic hsync_in = 1'b1, vsync_in = 1'b1;
  logic hsync_out, hsync_oe, vsync_out, vsync_oe, blank;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  raster_sync_gen #(.CW(CW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_in(hsync_in), .hsync_out(hsync_out), .hsync_oe(hsync_oe),
    .vsync_in(vsync_in), .vsync_out(vsync_out), .vsync_oe(vsync_oe), .blank(blank)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic wait_fall_v();
    logic prev;
    prev = vsync_out;
    tick();
    while (!(prev == 1'b1 && vsync_out == 1'b0)) begin
      prev = vsync_out;
      tick();
    end
  endtask

  task automatic wait_fall_h();
    logic prev;
    prev = hsync_out;
    tick();
    while (!(prev == 1'b1 && hsync_out == 1'b0)) begin
      prev = hsync_out;
      tick();
    end
  endtask

  // Cycle sweep from the first clock of a frame (R1, R2, R3; R10 with inject)
  task automatic sweep(input int ht, input int hs, input int hbs, input int hbe,
                       input int vt, input int vs, input int vbs, input int vbe,
                       input int frames, input bit inject);
    int h, v;
    wait_fall_v();
    for (int p = 0; p < frames * (ht + 1) * (vt + 1); p++) begin
      if (p > 0) tick();
      if (inject && p == 5) begin hsync_in = 1'b0; vsync_in = 1'b0; end
      if (inject && p == 50) begin hsync_in = 1'b1; vsync_in = 1'b1; end
      if (inject && p == 80) begin hsync_in = 1'b0; vsync_in = 1'b0; end
      h = p % (ht + 1);
      v = (p / (ht + 1)) % (vt + 1);
      chk(inject && p > 8 ? "R10 hsync" : "R1 hsync", hsync_out, !(h < hs));
      chk(inject && p > 8 ? "R10 vsync" : "R2 vsync", vsync_out, !(v < vs));
      chk("R3 blank", blank, (h >= hbs) || (h < hbe) || (v >= vbs) || (v < vbe));
    end
    hsync_in = 1'b1; vsync_in = 1'b1;
  endtask

  initial begin
    #160000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) tick();
    chk("R5 hsync_oe", hsync_oe, 1'b0);
    chk("R5 vsync_oe", vsync_oe, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R5 hsync_oe after release", hsync_oe, 1'b0);

    // R4 map, first raster 10 x 6
    wr(1, 2); wr(2, 1); wr(3, 7); wr(4, 9);
    wr(5, 1); wr(6, 1); wr(7, 4); wr(8, 5);
    wr(9, 1); wr(10, 2); wr(12, 0); wr(0, 3);
    repeat (300) tick();
    chk("R6 hsync_oe", hsync_oe, 1'b1);
    chk("R6 vsync_oe", vsync_oe, 1'b1);
    sweep(9, 2, 7, 1, 5, 1, 4, 1, 2, 1'b1);

    // second raster 7 x 4, staged
    wr(1, 3); wr(2, 0); wr(3, 5); wr(4, 6);
    wr(5, 2); wr(6, 0); wr(7, 3); wr(8, 3);
    repeat (150) tick();
    sweep(6, 3, 5, 0, 3, 2, 3, 0, 2, 1'b0);

    // R9: direction change waits for the frame end (frame = 28 clocks)
    wait_fall_v();
    wr(0, 0);
    for (int p = 1; p < 28; p++) begin
      if (p > 1) tick();
      chk("R9 hsync_oe held", hsync_oe, 1'b1);
    end
    tick();
    chk("R9 hsync_oe switched", hsync_oe, 1'b0);
    chk("R9 vsync_oe switched", vsync_oe, 1'b0);

    // R7: horizontal load to 1, from count 0
    wait_fall_h();
    hsync_in = 1'b0;
    tick(); tick(); tick();
    chk("R7 load h=1", hsync_out, 1'b0);
    tick();
    chk("R7 h=2", hsync_out, 1'b0);
    tick();
    chk("R7 h=3", hsync_out, 1'b1);
    tick(); tick(); tick();
    chk("R7 h=6", hsync_out, 1'b1);
    tick();
    chk("R7 wrap h=0", hsync_out, 1'b0);
    hsync_in = 1'b1;
    repeat (10) tick();

    // R8: vertical load to 2, from line 0
    wait_fall_v();
    vsync_in = 1'b0;
    tick(); tick(); tick();
    chk("R8 load v=2", vsync_out, 1'b1);
    for (int p = 4; p <= 13; p++) tick();
    chk("R8 v=3", vsync_out, 1'b1);
    tick();
    chk("R8 wrap v=0", vsync_out, 1'b0);
    vsync_in = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule